// File: doc/BRIEF.md
# SPI master serial clock generator

This block produces the serial clock for an SPI master, together with a one-cycle strobe that tells the shift logic when to present the next outgoing bit and another that tells it when to capture the incoming bit. It runs entirely on the fast peripheral clock. The serial clock period comes from a 7-bit divisor code: small codes are clamped to a divide-by-4 floor, and larger codes divide by the code plus one. Odd divisors are split unequally between the two clock levels, with the shorter part at the active level.

A transfer begins with a single-cycle start request while the block is idle. The word length, the idle level of the clock and the data phase mode are captured at that moment and held until the transfer ends. After the last bit the clock is back at its idle level, and a single-cycle done strobe marks the end. Shift registers, chip selects and any bus access sit outside this block and follow its strobes.

Top module: `spi_sclk_gen`

## Requirements
- R1: A divisor code of 0, 1, 2 or 3 gives a serial clock period of 4 peripheral-clock cycles.
- R2: A divisor code of 4 or more gives a period of code+1 cycles; code 127 gives 128 cycles.
- R3: During a transfer, every stretch of the serial clock at its active level (opposite to idle) lasts floor(N/2) cycles and every idle-level stretch inside the transfer lasts ceil(N/2) cycles, where N is the period.
- R4: While idle, `sclk` equals `cpol`, following a change of `cpol` one cycle later; in the cycle where `done` is high, `sclk` is at the captured idle level.
- R5: With `cpha`=1, `launch` is high in the cycle after start is accepted, the first clock edge (toward the active level) follows ceil(N/2) cycles later with `sample` high, `sample` is high on every edge toward the active level, and the remaining launches come on the edges back to idle.
- R6: With `cpha`=0, the first clock edge and `launch` both appear in the cycle after start is accepted, later launches come on each following edge toward the active level, and `sample` is high on each edge back to idle.
- R7: `word_len_m1` holds the word length minus one (0 means 1 bit, 15 means 16 bits); a transfer gives exactly that many `launch` and `sample` pulses and twice that many `sclk` changes, and `done` is high for one cycle at the last edge back to idle, counted from the acceptance edge as bits*N cycles for `cpha`=1 and (bits-1)*N+floor(N/2) cycles for `cpha`=0, with `busy` low in the same cycle.
- R8: A start request while `busy` is high has no effect on the running transfer.
- R9: Changes to `baud_rate`, `cpol`, `cpha` or `word_len_m1` during a transfer have no effect on it.
- R10: While `rst_n` is low at a clock edge, `sclk` takes the value of `cpol`, and `busy`, `done`, `launch` and `sample` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_rate | input | 7 | Divisor code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 1: data presented half a period before the sampling edge |
| word_len_m1 | input | 4 | Word length minus one |
| start | input | 1 | Single-cycle transfer request |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Present the next outgoing bit |
| sample | output | 1 | Capture the incoming bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Single-cycle end-of-transfer strobe |

## Verification
The assertions check on every cycle that each clock level inside a transfer lasts its computed half-period, that the launch and sample strobes never coincide and that the sample strobe lands on the edge the phase mode calls for. They also check that the captured configuration stays frozen while busy, that a start request during a transfer moves nothing until the next expiry, and that done is one cycle long at the idle level. Only the bench scenarios show the end-to-end numbers: the transfer length for each divisor class, the pulse counts per word length, the time of the first sample, and that mid-transfer start requests, configuration changes and reset leave the expected traces at the ports.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

   // Edge classification of a half-period expiry
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_LEAD  = 2'd1,
      EV_TRAIL = 2'd2
   } sclk_event_e;

endpackage

// File: rtl/spi_sclk_divsel.sv
module spi_sclk_divsel #(
   parameter int BAUD_W  = 7,
   parameter int MIN_DIV = 4,
   localparam int DIV_W  = BAUD_W + 1,
   localparam int HALF_W = BAUD_W
) (
   input  logic [BAUD_W-1:0] baud_i,
   output logic [HALF_W-1:0] half_short_o,
   output logic [HALF_W-1:0] half_long_o
);

   localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

   logic [DIV_W-1:0] raw_div;
   logic [DIV_W-1:0] div;
   logic [DIV_W-1:0] long_full;

   assign raw_div = {1'b0, baud_i} + DIV_W'(1);

   generate
      if (MIN_DIV > 1) begin : g_clamp
         assign div = (raw_div < MIN_DIV_V) ? MIN_DIV_V : raw_div;
      end else begin : g_pass
         assign div = raw_div;
      end
   endgenerate

   // Active level gets the shorter half on odd divisors
   assign half_short_o = div[DIV_W-1:1];
   assign long_full    = div - {1'b0, half_short_o};
   assign half_long_o  = long_full[HALF_W-1:0];

   always_comb begin
      assert_split_R3: assert ((half_long_o - half_short_o) <= HALF_W'(1))
         else $error("half split differs by more than one cycle");
   end

endmodule

// File: rtl/spi_sclk_halftimer.sv
module spi_sclk_halftimer #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   input  logic         run_i,
   output logic         expire_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= len_i - W'(1);
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign expire_o = (cnt_q == '0);

   assert_min_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (len_i >= W'(2)))
      else $error("half-period shorter than two cycles loaded");

   assert_no_early_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !expire_o)
      else $error("timer expired right after a load");

endmodule

// File: rtl/spi_sclk_seq.sv
module spi_sclk_seq
   import spi_sclk_pkg::*;
#(
   parameter int HALF_W = 7,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic [LEN_W-1:0]  len_m1_i,
   input  logic [HALF_W-1:0] hs_i,
   input  logic [HALF_W-1:0] hl_i,
   input  logic              expire_i,
   output logic              load_o,
   output logic [HALF_W-1:0] load_len_o,
   output logic              run_o,
   output logic              sclk_o,
   output logic              launch_o,
   output logic              sample_o,
   output logic              done_o,
   output logic              busy_o
);

   logic              busy_q, sclk_q, pol_q, pha_q;
   logic              launch_q, sample_q, done_q;
   logic [HALF_W-1:0] hs_q, hl_q;
   logic [LEN_W-1:0]  bits_q;
   logic              accept, last_bit;
   sclk_event_e       ev;

   assign accept   = !busy_q && start_i;
   assign last_bit = (bits_q == '0);

   always_comb begin
      if (!busy_q || !expire_i) ev = EV_NONE;
      else if (sclk_q == pol_q) ev = EV_LEAD;
      else                      ev = EV_TRAIL;
   end

   assign load_o     = accept || (ev == EV_LEAD) || ((ev == EV_TRAIL) && !last_bit);
   assign load_len_o = accept ? (cpha_i ? hl_i : hs_i)
                              : ((ev == EV_LEAD) ? hs_q : hl_q);
   assign run_o      = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sclk_q   <= cpol_i;
         pol_q    <= cpol_i;
         pha_q    <= 1'b0;
         hs_q     <= '0;
         hl_q     <= '0;
         bits_q   <= '0;
         launch_q <= 1'b0;
         sample_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         launch_q <= 1'b0;
         sample_q <= 1'b0;
         done_q   <= 1'b0;
         if (!busy_q) begin
            pol_q  <= cpol_i;
            pha_q  <= cpha_i;
            hs_q   <= hs_i;
            hl_q   <= hl_i;
            bits_q <= len_m1_i;
            sclk_q <= cpol_i;
            if (start_i) begin
               busy_q   <= 1'b1;
               launch_q <= 1'b1;
               if (!cpha_i) sclk_q <= ~cpol_i;
            end
         end else begin
            case (ev)
               EV_LEAD: begin
                  sclk_q <= ~pol_q;
                  if (pha_q) sample_q <= 1'b1;
                  else       launch_q <= 1'b1;
               end
               EV_TRAIL: begin
                  sclk_q <= pol_q;
                  if (!pha_q) sample_q <= 1'b1;
                  if (last_bit) begin
                     done_q <= 1'b1;
                     busy_q <= 1'b0;
                  end else begin
                     bits_q <= bits_q - LEN_W'(1);
                     if (pha_q) launch_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sclk_o   = sclk_q;
   assign launch_o = launch_q;
   assign sample_o = sample_q;
   assign done_o   = done_q;
   assign busy_o   = busy_q;

   // Checker: length of each clock level inside a transfer
   logic              sclk_prev, seen_edge;
   logic [HALF_W:0]   hold_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         seen_edge <= 1'b0;
         hold_cnt  <= '0;
      end else begin
         sclk_prev <= sclk_q;
         if (sclk_q != sclk_prev) hold_cnt <= (HALF_W+1)'(1);
         else if (hold_cnt != '1) hold_cnt <= hold_cnt + (HALF_W+1)'(1);
         if (!busy_q && !done_q) seen_edge <= 1'b0;
         else if (busy_q && (sclk_q != sclk_prev)) seen_edge <= 1'b1;
      end
   end

   assert_half_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((busy_q || done_q) && seen_edge && (sclk_q != sclk_prev)) |->
         (hold_cnt == {1'b0, ((sclk_prev != pol_q) ? hs_q : hl_q)}))
      else $error("clock level held for the wrong number of cycles");

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_q && launch_q))
      else $error("launch and sample in the same cycle");

   assert_sample_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_q |-> (pha_q ? (sclk_q != pol_q) : (sclk_q == pol_q)))
      else $error("sample strobe on the wrong clock edge");

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((sclk_q == pol_q) && !busy_q))
      else $error("transfer ended away from the idle level");

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q)
      else $error("done longer than one cycle");

   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |->
         ($stable(pol_q) && $stable(pha_q) && $stable(hs_q) && $stable(hl_q)))
      else $error("configuration moved during a transfer");

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !expire_i) |=> ($stable(sclk_q) && !launch_q && busy_q))
      else $error("start during a transfer disturbed it");

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
   parameter int BAUD_W   = 7,
   parameter int MAX_BITS = 16,
   parameter int MIN_DIV  = 4,
   localparam int LEN_W   = $clog2(MAX_BITS),
   localparam int HALF_W  = BAUD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BAUD_W-1:0] baud_rate,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  word_len_m1,
   input  logic              start,
   output logic              sclk,
   output logic              launch,
   output logic              sample,
   output logic              busy,
   output logic              done
);

   initial begin
      assert_param_baud: assert (BAUD_W >= 3) else $error("BAUD_W too small");
      assert_param_bits: assert (MAX_BITS >= 2 && (1 << LEN_W) == MAX_BITS)
         else $error("MAX_BITS must be a power of two");
      assert_param_min_R1: assert (MIN_DIV >= 4 && MIN_DIV <= (1 << BAUD_W))
         else $error("MIN_DIV out of range");
   end

   logic [HALF_W-1:0] half_short, half_long, load_len;
   logic              load, run, expire;

   spi_sclk_divsel #(
      .BAUD_W  (BAUD_W),
      .MIN_DIV (MIN_DIV)
   ) u_divsel (
      .baud_i       (baud_rate),
      .half_short_o (half_short),
      .half_long_o  (half_long)
   );

   spi_sclk_halftimer #(
      .W (HALF_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .len_i    (load_len),
      .run_i    (run),
      .expire_o (expire)
   );

   spi_sclk_seq #(
      .HALF_W (HALF_W),
      .LEN_W  (LEN_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .cpol_i     (cpol),
      .cpha_i     (cpha),
      .len_m1_i   (word_len_m1),
      .hs_i       (half_short),
      .hl_i       (half_long),
      .expire_i   (expire),
      .load_o     (load),
      .load_len_o (load_len),
      .run_o      (run),
      .sclk_o     (sclk),
      .launch_o   (launch),
      .sample_o   (sample),
      .done_o     (done),
      .busy_o     (busy)
   );

endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] baud_rate = '0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic [3:0] word_len_m1 = '0;
   logic       start = 1'b0;
   logic       sclk, launch, sample, busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_sclk_gen i_spi_sclk_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_rate   (baud_rate),
      .cpol        (cpol),
      .cpha        (cpha),
      .word_len_m1 (word_len_m1),
      .start       (start),
      .sclk        (sclk),
      .launch      (launch),
      .sample      (sample),
      .busy        (busy),
      .done        (done)
   );

   // {divisor code, idle level, phase, length-1}
   localparam int NV = 8;
   localparam logic [12:0] VEC [NV] = '{
      {7'd0,   1'b0, 1'b0, 4'd7},
      {7'd1,   1'b1, 1'b1, 4'd0},
      {7'd2,   1'b0, 1'b1, 4'd15},
      {7'd3,   1'b1, 1'b0, 4'd3},
      {7'd4,   1'b0, 1'b0, 4'd2},
      {7'd6,   1'b1, 1'b1, 4'd1},
      {7'd127, 1'b0, 1'b1, 4'd0},
      {7'd10,  1'b1, 1'b0, 4'd4}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int div_of(input int b);
      return (b < 4) ? 4 : b + 1;
   endfunction

   // mode 0 plain, 1 extra start mid-transfer, 2 config change mid-transfer
   task automatic xfer(input logic [6:0] b, input logic p, input logic h,
                       input logic [3:0] l, input int mode,
                       output int t_done, output int act_cnt, output int smp,
                       output int lch, output int first_smp, output int edges,
                       output int done_after, output int idle_at_done);
      logic prev;
      bit   found;
      int   k;
      t_done = -1; act_cnt = 0; smp = 0; lch = 0; first_smp = -1;
      edges = 0; done_after = 0; idle_at_done = 0;
      @(negedge clk);
      baud_rate = b; cpol = p; cpha = h; word_len_m1 = l; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev = p; found = 0; k = 0;
      while (!found && k < 3000) begin
         if (mode == 1 && k == 2) start = 1'b1;
         if (mode == 1 && k == 3) start = 1'b0;
         if (mode == 2 && k == 2) begin
            baud_rate = ~b; cpol = ~p; cpha = ~h; word_len_m1 = ~l;
         end
         if (sclk != prev) edges++;
         prev = sclk;
         smp += int'(sample);
         lch += int'(launch);
         if (sample && first_smp < 0) first_smp = k;
         if (done) begin
            found = 1;
            t_done = k;
            idle_at_done = int'(sclk == p && !busy);
         end else begin
            if (sclk != p) act_cnt++;
            @(negedge clk);
            k++;
         end
      end
      @(negedge clk);
      done_after = int'(done);
      baud_rate = b; cpol = p; cpha = h; word_len_m1 = l;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R7 actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int t, a, s, ln, f, e, da, id;
      int n, hs, hl, bits, exp_t;
      string rq;

      // R10: reset state
      cpol = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10", "sclk in reset", int'(sclk), 1);
      chk("R10", "busy in reset", int'(busy), 0);
      chk("R10", "strobes in reset", int'(done | launch | sample), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cpol = 1'b0;
      @(negedge clk);
      chk("R4", "idle sclk follows cpol low", int'(sclk), 0);
      cpol = 1'b1;
      @(negedge clk);
      chk("R4", "idle sclk follows cpol high", int'(sclk), 1);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [6:0] b; logic p, h; logic [3:0] l;
         {b, p, h, l} = VEC[i];
         n = div_of(int'(b)); hs = n / 2; hl = n - hs; bits = int'(l) + 1;
         exp_t = h ? bits * n : (bits - 1) * n + hs;
         rq = (b < 4) ? "R1" : "R2";
         xfer(b, p, h, l, 0, t, a, s, ln, f, e, da, id);
         chk(rq, "cycles to done", t, exp_t);
         chk("R3", "active-level cycles", a, bits * hs);
         chk("R7", "sample count", s, bits);
         chk("R7", "launch count", ln, bits);
         chk("R7", "sclk changes", e, 2 * bits);
         chk("R7", "done width", da, 0);
         chk("R4", "idle at done", id, 1);
         if (h) chk("R5", "first sample cycle", f, hl);
         else   chk("R6", "first sample cycle", f, hs);
      end

      // R8: start during a transfer
      n = div_of(9); hs = n / 2; bits = 4;
      xfer(7'd9, 1'b0, 1'b1, 4'd3, 1, t, a, s, ln, f, e, da, id);
      chk("R8", "cycles to done with extra start", t, bits * n);
      chk("R8", "launch count with extra start", ln, bits);
      chk("R8", "no second transfer", da, 0);
      @(negedge clk);
      chk("R8", "idle after transfer", int'(busy), 0);

      // R9: configuration change during a transfer
      n = div_of(5); hs = n / 2; bits = 3;
      xfer(7'd5, 1'b1, 1'b0, 4'd2, 2, t, a, s, ln, f, e, da, id);
      chk("R9", "cycles to done after cfg change", t, (bits - 1) * n + hs);
      chk("R9", "active cycles after cfg change", a, bits * hs);
      chk("R9", "sample count after cfg change", s, bits);
      chk("R9", "idle at done after cfg change", id, 1);

      // R10: reset in the middle of a transfer
      @(negedge clk);
      baud_rate = 7'd20; cpol = 1'b0; cpha = 1'b0; word_len_m1 = 4'd15; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk("R10", "busy before mid reset", int'(busy), 1);
      rst_n = 1'b0;
      cpol = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10", "sclk after mid reset", int'(sclk), 1);
      chk("R10", "busy after mid reset", int'(busy), 0);
      rst_n = 1'b1;
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            seen += int'(done | launch | sample);
         end
         chk("R10", "no strobes after reset", seen, 0);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule